// File: doc/BRIEF.md
# Timed Sleep Controller with Chip-Select Wake

This block governs a timed shutdown interval for a sensor that a host reaches over a serial port. The host writes an 8-bit sleep count while its chip-select is held low. Once chip-select returns high, the block raises its sleep output. Each half-second tick while asleep removes one unit from the remaining count. When the count is used up, the block releases sleep by itself, without any host action. A count of six therefore holds sleep for six ticks, or three seconds.

The host can end the interval early by pulling the active-low chip-select line low. Sleep drops on the next clock edge and the remaining count is discarded, so raising chip-select again does not resume sleep. A count of zero never starts an interval. Writing zero before chip-select rises cancels an earlier nonzero count. The awake status is high only when the block is neither asleep nor holding an armed count.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, sleep is low, awake is high, and no count is armed.
- R2: A write of a nonzero count arms the block. From the edge that captures the write, awake is low, and sleep stays low while chip-select (cs_n) is low.
- R3: Sleep rises on the clock edge that first samples cs_n high with a count armed and no write in that cycle. It never rises while cs_n is low.
- R4: A written count of 0 does not start sleep. Writing 0 while a count is armed cancels it, and awake returns high.
- R5: An interval started with count N lasts exactly N half_tick pulses. Sleep falls, and awake rises, on the edge that samples the Nth pulse.
- R6: While asleep with cs_n high and no half_tick, sleep stays high and the remaining count does not change.
- R7: cs_n low while asleep clears sleep on the next edge, sets awake and discards the remaining count. A later rise of cs_n does not bring sleep back.
- R8: If several counts are written before cs_n rises, only the last one counts (last write wins).
- R9: Sleep and awake are never high together. Awake is low while a count is armed.
- R10: A half_tick in the same cycle in which sleep is entered does not shorten the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle strobe that writes the sleep count |
| wr_data | input | 8 | Sleep count, in units of 0.5 s |
| half_tick | input | 1 | One-cycle pulse, once every half second |
| cs_n | input | 1 | Active-low chip-select from the host |
| sleep | output | 1 | High while the sensor is shut down |
| awake | output | 1 | High when not asleep and no count is armed |

## Verification
A remaining count that is one unit off shows up at the ports within a single interval: sleep falls one tick early or one tick late. Each directed interval is therefore checked on the tick just before release and on the releasing tick. A stale armed value shows up at the very next rise of chip-select as a sleep that should not happen. The bench looks for it after a chip-select wake and after a write of zero. Entry timing is sampled on the exact edge that first sees chip-select high.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } sc_state_e;

  // Remaining count after one consumed tick
  function automatic logic [7:0] sc_step_down(input logic [7:0] remain);
    return remain - 8'd1;
  endfunction

  // True when the tick being consumed is the last one
  function automatic logic sc_is_final(input logic [7:0] remain);
    return remain == 8'd1;
  endfunction

endpackage

// File: rtl/sc_arm_latch.sv
module sc_arm_latch #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          take,
  output logic [CW-1:0] value,
  output logic          pending
);
  logic [CW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (wr_en)  held_q <= wr_data;
    else if (take)   held_q <= '0;
  end

  assign value   = held_q;
  assign pending = |held_q;
endmodule

// File: rtl/sc_interval_counter.sv
module sc_interval_counter
  import sleep_ctrl_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          asleep,
  input  logic          wake,
  input  logic          half_tick,
  output logic [CW-1:0] remain,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic          consume;

  assign consume = asleep && !wake && half_tick;
  assign expire  = consume && sc_is_final(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (wake || expire)   cnt_q <= '0;
    else if (consume)          cnt_q <= sc_step_down(cnt_q);
  end

  assign remain = cnt_q;
endmodule

// File: rtl/sc_sleep_fsm.sv
module sc_sleep_fsm
  import sleep_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic wr_en,
  input  logic cs_n,
  input  logic expire,
  output logic asleep,
  output logic enter,
  output logic wake
);
  sc_state_e state_q, state_d;

  assign enter = (state_q == ST_AWAKE) && pending && cs_n && !wr_en;
  assign wake  = (state_q == ST_ASLEEP) && !cs_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:  if (enter)          state_d = ST_ASLEEP;
      ST_ASLEEP: if (wake || expire) state_d = ST_AWAKE;
      default:                       state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_AWAKE;
    else        state_q <= state_d;
  end

  assign asleep = (state_q == ST_ASLEEP);
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          half_tick,
  input  logic          cs_n,
  output logic          sleep,
  output logic          awake
);
  logic [CW-1:0] armed_val;
  logic [CW-1:0] remain;
  logic          armed;
  logic          asleep;
  logic          enter_evt;
  logic          wake_evt;
  logic          expire_evt;

  sc_arm_latch #(.CW(CW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (enter_evt),
    .value   (armed_val),
    .pending (armed)
  );

  sc_sleep_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (armed),
    .wr_en   (wr_en),
    .cs_n    (cs_n),
    .expire  (expire_evt),
    .asleep  (asleep),
    .enter   (enter_evt),
    .wake    (wake_evt)
  );

  sc_interval_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (enter_evt),
    .load_val  (armed_val),
    .asleep    (asleep),
    .wake      (wake_evt),
    .half_tick (half_tick),
    .remain    (remain),
    .expire    (expire_evt)
  );

  assign sleep = asleep;
  assign awake = !asleep && !armed;
endmodule

// File: rtl/sleep_ctrl_checker.sv
module sleep_ctrl_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic          half_tick,
  input logic          cs_n,
  input logic          sleep,
  input logic          awake,
  input logic [CW-1:0] remain,
  input logic          enter_evt,
  input logic          expire_evt
);
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep && awake)); // R9

  AST_NO_ENTRY_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cs_n) |=> !sleep); // R3

  AST_ENTRY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> (sleep && remain != '0)); // R3

  AST_ZERO_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && wr_en && wr_data == '0) |=> (!sleep && awake)); // R4

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && cs_n && !half_tick) |=> (sleep && $stable(remain))); // R6

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && cs_n && half_tick && remain > CW'(1)) |=> (sleep && remain == $past(remain) - CW'(1))); // R5

  AST_EXPIRE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> !sleep); // R5

  AST_CS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !cs_n) |=> (!sleep && remain == '0)); // R7
endmodule

bind sleep_ctrl sleep_ctrl_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .half_tick  (half_tick),
  .cs_n       (cs_n),
  .sleep      (sleep),
  .awake      (awake),
  .remain     (remain),
  .enter_evt  (enter_evt),
  .expire_evt (expire_evt)
);

// File: tb/sleep_ctrl_test.sv
`timescale 1ns/1ps
module sleep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       half_tick = 1'b0;
  logic       cs_n = 1'b1;
  logic       sleep;
  logic       awake;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .half_tick(half_tick), .cs_n(cs_n), .sleep(sleep), .awake(awake)
  );

  localparam int NV = 6;
  localparam logic [7:0] VALS [NV] = '{8'd1, 8'd6, 8'd2, 8'd0, 8'd13, 8'd3};

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write a count during a chip-select low window; cs_n stays low afterwards
  task automatic host_write(input logic [7:0] v);
    cs_n = 1'b0; wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic tick();
    half_tick = 1'b1;
    step();
    half_tick = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    step(); step();
    check("R1 sleep after reset", {7'd0, sleep}, 8'd0);
    check("R1 awake after reset", {7'd0, awake}, 8'd1);
    rst_n = 1'b1;
    step();
    cs_n = 1'b1;
    step();
    check("R1 no armed count after reset", {7'd0, sleep}, 8'd0);

    // Table-driven intervals
    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      v = VALS[i];
      host_write(v);
      check("R2 awake after write", {7'd0, awake}, (v != 0) ? 8'd0 : 8'd1);
      step();
      check("R2 no sleep while cs_n low", {7'd0, sleep}, 8'd0);
      cs_n = 1'b1;
      step();
      check("R3 sleep on cs_n rise (R4 for zero)", {7'd0, sleep}, (v != 0) ? 8'd1 : 8'd0);
      check("R9 awake while asleep", {7'd0, awake}, (v != 0) ? 8'd0 : 8'd1);
      for (int k = 1; k <= int'(v); k++) begin
        step();
        tick();
        if (k == int'(v) - 1)
          check("R5 sleep held before last tick", {7'd0, sleep}, 8'd1);
        if (k == int'(v)) begin
          check("R5 sleep released on last tick", {7'd0, sleep}, 8'd0);
          check("R5 awake after release", {7'd0, awake}, 8'd1);
        end
      end
      step();
    end

    // R6: hold without ticks
    host_write(8'd2);
    step();
    cs_n = 1'b1;
    step();
    for (int j = 0; j < 20; j++) step();
    check("R6 sleep held without ticks", {7'd0, sleep}, 8'd1);
    tick();
    check("R6 count not consumed while idle", {7'd0, sleep}, 8'd1);
    tick();
    check("R6 remaining count intact", {7'd0, sleep}, 8'd0);

    // R7: chip-select wake and no resume
    host_write(8'd10);
    step();
    cs_n = 1'b1;
    step();
    tick(); tick(); tick();
    check("R7 asleep before wake", {7'd0, sleep}, 8'd1);
    cs_n = 1'b0;
    step();
    check("R7 sleep cleared by cs_n low", {7'd0, sleep}, 8'd0);
    check("R7 awake after cs wake", {7'd0, awake}, 8'd1);
    cs_n = 1'b1;
    step(); step();
    check("R7 no resume after cs_n rise", {7'd0, sleep}, 8'd0);

    // R4: zero cancels armed count
    host_write(8'd5);
    host_write(8'd0);
    check("R4 awake after cancel", {7'd0, awake}, 8'd1);
    cs_n = 1'b1;
    step(); step();
    check("R4 no sleep after cancel", {7'd0, sleep}, 8'd0);

    // R8: last write wins
    host_write(8'd5);
    host_write(8'd2);
    cs_n = 1'b1;
    step();
    check("R8 asleep with rewritten count", {7'd0, sleep}, 8'd1);
    tick();
    check("R8 held after first tick", {7'd0, sleep}, 8'd1);
    tick();
    check("R8 released after two ticks", {7'd0, sleep}, 8'd0);

    // R10: tick in entry cycle ignored
    host_write(8'd2);
    cs_n = 1'b1;
    half_tick = 1'b1;
    step();
    half_tick = 1'b0;
    check("R10 entered with coincident tick", {7'd0, sleep}, 8'd1);
    tick();
    check("R10 entry tick not counted", {7'd0, sleep}, 8'd1);
    tick();
    check("R10 release after full count", {7'd0, sleep}, 8'd0);

    step();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule